// File: doc/BRIEF.md
# Two-Way Slot Mailbox

This block links a host processor to a peer engine through two circular buffers of 32-bit slots, one for each direction. The host sees four registers on a small 32-bit register bus: a push window into the host-to-peer ring, its own control/status word, a pop window out of the peer-to-host ring, and a read-only copy of the peer's status word. The peer fills and drains the rings through a plain strobe port and can see the fill level of each ring.

Every ring keeps a free-running 8-bit write pointer and an 8-bit read pointer. The number of occupied slots is their difference modulo 256, and the ring depth is published next to them, so software finds the free space by subtraction. Interrupts travel both ways. The peer raises a pulse that latches a status bit on the host side, and a host write raises a one-cycle pulse toward the peer. A reset bit flushes both rings, and a pair of ready flags lets the two sides agree again that the channel is live.

Top module: `slot_mailbox`

## Requirements
- R1: A host write at offset 0x00 stores the data word at the tail of the host-to-peer ring and advances that ring's write pointer by one. The peer receives the words in the order written on `pe_rd_data`, and each `pe_rd_en` removes one word.
- R2: A host read at offset 0x08 returns the oldest word of the peer-to-host ring and advances that ring's read pointer by one. Words pushed by the peer with `pe_wr_en` come out in order.
- R3: Host status word at 0x04 has this layout: bit0 IE, bit1 IS, bit2 IG (always reads 0), bit3 host READY, bit4 RESET, bit5 overflow flag, bit6 underflow flag, bits 15:8 host-to-peer read pointer, bits 23:16 host-to-peer write pointer, bits 31:24 depth. Peer status word at 0x0C has the peer READY input in bit3, bits 15:8 and 23:16 the peer-to-host read and write pointers, and the depth in bits 31:24. All other bits read 0. Reads of 0x00 return 0.
- R4: A host write to a full host-to-peer ring is dropped and sets the overflow flag (bit5). The flag stays set until the host writes 1 to bit5 at 0x04.
- R5: A host read of an empty peer-to-host ring returns 0, leaves the pointers unchanged and sets the underflow flag (bit6). Writing 1 to bit6 at 0x04 clears it.
- R6: Pointers are 8 bits wide and wrap from 255 to 0. The fill level is the write pointer minus the read pointer modulo 256 and never exceeds the depth, including across wraps and with a push and a pop in the same cycle.
- R7: A `pe_irq_gen` pulse sets IS. Writing 1 to bit1 at 0x04 clears IS, and if both happen in the same cycle the set wins. `host_irq` is high exactly while IE and IS are both 1.
- R8: A write at 0x04 with bit2 set drives `pe_irq` high for exactly the next cycle.
- R9: While RESET is 1, both rings ignore pushes and pops with no error flagged, and their pointers read 0 from the cycle after RESET is registered. `host_reset` and `host_ready` mirror the RESET and READY bits.
- R10: After `rst_n` both rings are empty with all pointers at 0, and IE, IS, READY, RESET and both error flags are 0.
- R11: Host writes at 0x08 and 0x0C change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| host_irq | output | 1 | Host interrupt, IE and IS |
| host_ready | output | 1 | Host READY bit |
| host_reset | output | 1 | Host RESET bit |
| pe_irq | output | 1 | One-cycle interrupt pulse to the peer |
| pe_irq_gen | input | 1 | Peer request to interrupt the host |
| pe_ready | input | 1 | Peer READY flag |
| pe_rd_en | input | 1 | Peer removes one word from the host-to-peer ring |
| pe_rd_data | output | 32 | Oldest word of the host-to-peer ring |
| pe_h2p_level | output | 8 | Occupied slots in the host-to-peer ring |
| pe_wr_en | input | 1 | Peer adds one word to the peer-to-host ring |
| pe_wr_data | input | 32 | Word the peer adds |
| pe_p2h_level | output | 8 | Occupied slots in the peer-to-host ring |

## Verification
A pointer that slips by one shows up in the same cycle as a wrong fill level on the peer port, and shows up as a wrong field on the next status read. It also makes the data word leaving the pop window or reaching `pe_rd_data` wrong. A full or empty decision taken on stale pointers shows up one cycle later, either as a level above the depth or as a sticky error flag in the host status word. Interrupt state held wrongly shows up on `host_irq` or `pe_irq` at the first edge after the event that should have moved it. For that reason the outputs are compared with a queue-based model on every clock.

// File: rtl/slot_mailbox_pkg.sv
// Shared offsets, field positions and helpers for the slot mailbox.
// Assumes a byte-addressed bus with 32-bit registers at 4-byte steps.
package slot_mailbox_pkg;
    localparam int SLOT_W   = 32;
    localparam int PTR_W    = 8;

    localparam int OFF_PUSH = 4'h0;
    localparam int OFF_HCSR = 4'h4;
    localparam int OFF_POP  = 4'h8;
    localparam int OFF_PCSR = 4'hC;

    localparam int B_IE    = 0;
    localparam int B_IS    = 1;
    localparam int B_IG    = 2;
    localparam int B_RDY   = 3;
    localparam int B_RST   = 4;
    localparam int B_OVF   = 5;
    localparam int B_UDF   = 6;

    // Occupancy of a ring from its free-running pointers
    function automatic logic [PTR_W-1:0] occupancy(input logic [PTR_W-1:0] wp,
                                                   input logic [PTR_W-1:0] rp);
        return wp - rp;
    endfunction

    // Assemble a status word from its fields
    function automatic logic [SLOT_W-1:0] pack_status(input logic [PTR_W-1:0] depth,
                                                      input logic [PTR_W-1:0] wp,
                                                      input logic [PTR_W-1:0] rp,
                                                      input logic [7:0]       flags);
        return {depth, wp, rp, flags};
    endfunction
endpackage

// File: rtl/slot_ring.sv
// One circular buffer of fixed-width slots with free-running 8-bit pointers.
// Assumes DEPTH is between 1 and 255. Storage indices wrap at DEPTH while the
// visible pointers wrap at 256, so occupancy stays exact for any depth.
// A flush holds both pointers at zero and blocks every push and pop.
module slot_ring
    import slot_mailbox_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] fill,
    output logic             full,
    output logic             empty,
    output logic             push_ok,
    output logic             pop_ok
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [IDX_W-1:0] widx, ridx;

    // Derive occupancy and accepted operations
    always_comb begin
        fill    = occupancy(wr_ptr, rd_ptr);
        full    = (fill == DEPTH_P);
        empty   = (fill == '0);
        push_ok = push && !flush && !full;
        pop_ok  = pop  && !flush && !empty;
        head    = mem[ridx];
    end

    // Store accepted slots
    always_ff @(posedge clk) begin
        if (push_ok) mem[widx] <= push_data;
    end

    // Advance or clear the write side
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            widx   <= '0;
        end else if (push_ok) begin
            wr_ptr <= wr_ptr + 1'b1;
            widx   <= (widx == LAST) ? '0 : widx + 1'b1;
        end
    end

    // Advance or clear the read side
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            ridx   <= '0;
        end else if (pop_ok) begin
            rd_ptr <= rd_ptr + 1'b1;
            ridx   <= (ridx == LAST) ? '0 : ridx + 1'b1;
        end
    end
endmodule

// File: rtl/mbox_irq_ctl.sv
// Interrupt state for both directions of the mailbox.
// Assumes csr_wr marks a host write to its status word. A peer set and a
// host clear in the same cycle leave the status bit set.
module mbox_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic csr_wr,
    input  logic wr_ie,
    input  logic wr_is_clr,
    input  logic wr_ig,
    input  logic peer_gen,
    output logic ie,
    output logic is_flag,
    output logic host_irq,
    output logic peer_pulse
);
    // Enable bit follows host writes
    always_ff @(posedge clk) begin
        if (!rst_n)      ie <= 1'b0;
        else if (csr_wr) ie <= wr_ie;
    end

    // Status bit: set by the peer, cleared by a host write of one
    always_ff @(posedge clk) begin
        if (!rst_n)                   is_flag <= 1'b0;
        else if (peer_gen)            is_flag <= 1'b1;
        else if (csr_wr && wr_is_clr) is_flag <= 1'b0;
    end

    // One-cycle pulse toward the peer on a generate write
    always_ff @(posedge clk) begin
        if (!rst_n) peer_pulse <= 1'b0;
        else        peer_pulse <= csr_wr && wr_ig;
    end

    // Host interrupt line
    always_comb host_irq = ie && is_flag;
endmodule

// File: rtl/slot_mailbox.sv
// Register-mapped two-way slot mailbox between a host and a peer engine.
// Assumes single-cycle bus strobes; read data is combinational in the strobe
// cycle and any read side effect takes place at the closing edge.
module slot_mailbox
    import slot_mailbox_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              host_irq,
    output logic              host_ready,
    output logic              host_reset,
    output logic              pe_irq,
    input  logic              pe_irq_gen,
    input  logic              pe_ready,
    input  logic              pe_rd_en,
    output logic [31:0]       pe_rd_data,
    output logic [7:0]        pe_h2p_level,
    input  logic              pe_wr_en,
    input  logic [31:0]       pe_wr_data,
    output logic [7:0]        pe_p2h_level
);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    logic sel_push, sel_hcsr, sel_pop, sel_pcsr;
    logic wr_push, wr_hcsr, rd_pop;
    logic [PTR_W-1:0] h_wp, h_rp, h_fill, p_wp, p_rp, p_fill;
    logic h_full, h_empty, h_push_ok, h_pop_ok;
    logic p_full, p_empty, p_push_ok, p_pop_ok;
    logic [31:0] p_head;
    logic ovf, udf, ie, is_flag;

    // Address decode and qualified strobes
    always_comb begin
        sel_push = (bus_addr == ADDR_W'(OFF_PUSH));
        sel_hcsr = (bus_addr == ADDR_W'(OFF_HCSR));
        sel_pop  = (bus_addr == ADDR_W'(OFF_POP));
        sel_pcsr = (bus_addr == ADDR_W'(OFF_PCSR));
        wr_push  = bus_wr && sel_push;
        wr_hcsr  = bus_wr && sel_hcsr;
        rd_pop   = bus_rd && sel_pop;
    end

    slot_ring #(.DEPTH(DEPTH), .W(32)) u_h2p (
        .clk(clk), .rst_n(rst_n), .flush(host_reset),
        .push(wr_push), .push_data(bus_wdata), .pop(pe_rd_en), .head(pe_rd_data),
        .wr_ptr(h_wp), .rd_ptr(h_rp), .fill(h_fill), .full(h_full), .empty(h_empty),
        .push_ok(h_push_ok), .pop_ok(h_pop_ok)
    );

    slot_ring #(.DEPTH(DEPTH), .W(32)) u_p2h (
        .clk(clk), .rst_n(rst_n), .flush(host_reset),
        .push(pe_wr_en), .push_data(pe_wr_data), .pop(rd_pop), .head(p_head),
        .wr_ptr(p_wp), .rd_ptr(p_rp), .fill(p_fill), .full(p_full), .empty(p_empty),
        .push_ok(p_push_ok), .pop_ok(p_pop_ok)
    );

    mbox_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n), .csr_wr(wr_hcsr),
        .wr_ie(bus_wdata[B_IE]), .wr_is_clr(bus_wdata[B_IS]), .wr_ig(bus_wdata[B_IG]),
        .peer_gen(pe_irq_gen), .ie(ie), .is_flag(is_flag),
        .host_irq(host_irq), .peer_pulse(pe_irq)
    );

    // Host READY and RESET bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_ready <= 1'b0;
            host_reset <= 1'b0;
        end else if (wr_hcsr) begin
            host_ready <= bus_wdata[B_RDY];
            host_reset <= bus_wdata[B_RST];
        end
    end

    // Sticky overflow flag, write one to clear
    always_ff @(posedge clk) begin
        if (!rst_n)                              ovf <= 1'b0;
        else if (wr_push && !host_reset && h_full) ovf <= 1'b1;
        else if (wr_hcsr && bus_wdata[B_OVF])    ovf <= 1'b0;
    end

    // Sticky underflow flag, write one to clear
    always_ff @(posedge clk) begin
        if (!rst_n)                               udf <= 1'b0;
        else if (rd_pop && !host_reset && p_empty) udf <= 1'b1;
        else if (wr_hcsr && bus_wdata[B_UDF])     udf <= 1'b0;
    end

    // Register read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (sel_hcsr)
            bus_rdata = pack_status(DEPTH_P, h_wp, h_rp,
                                    {1'b0, udf, ovf, host_reset, host_ready, 1'b0, is_flag, ie});
        else if (sel_pcsr)
            bus_rdata = pack_status(DEPTH_P, p_wp, p_rp, {4'b0, pe_ready, 3'b0});
        else if (sel_pop && !p_empty && !host_reset)
            bus_rdata = p_head;
    end

    // Levels seen by the peer
    always_comb begin
        pe_h2p_level = h_fill;
        pe_p2h_level = p_fill;
    end
endmodule

// File: rtl/slot_mailbox_chk.sv
// Temporal checks for the slot mailbox, bound onto every instance of the top.
module slot_mailbox_chk #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              host_irq,
    input logic              host_reset,
    input logic              pe_irq,
    input logic              pe_irq_gen,
    input logic              pe_rd_en,
    input logic [7:0]        pe_h2p_level,
    input logic [7:0]        pe_p2h_level
);
    // R6
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_h2p_level <= 8'(DEPTH)) && (pe_p2h_level <= 8'(DEPTH)));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0) && pe_h2p_level == 8'(DEPTH) && !pe_rd_en && !host_reset)
        |=> $stable(pe_h2p_level));

    // R5
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(8) && pe_p2h_level == 8'd0) |-> (bus_rdata == 32'd0));

    // R8
    ig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_irq |-> $past(bus_wr && bus_addr == ADDR_W'(4) && bus_wdata[2]));

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> ($past(pe_irq_gen) || $past(bus_wr && bus_addr == ADDR_W'(4) && bus_wdata[0])));

    // R9
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_reset |=> (pe_h2p_level == 8'd0 && pe_p2h_level == 8'd0));
endmodule

bind slot_mailbox slot_mailbox_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_irq(host_irq),
    .host_reset(host_reset), .pe_irq(pe_irq), .pe_irq_gen(pe_irq_gen),
    .pe_rd_en(pe_rd_en), .pe_h2p_level(pe_h2p_level), .pe_p2h_level(pe_p2h_level)
);

// File: tb/slot_mailbox_tb.sv
module slot_mailbox_tb;
    localparam int D = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 0, bus_rd = 0;
    logic [3:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic host_irq, host_ready, host_reset, pe_irq;
    logic pe_irq_gen = 0, pe_ready = 0, pe_rd_en = 0, pe_wr_en = 0;
    logic [31:0] pe_rd_data, pe_wr_data = '0;
    logic [7:0] pe_h2p_level, pe_p2h_level;

    always #2 clk = ~clk;

    slot_mailbox #(.DEPTH(D), .ADDR_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_irq(host_irq),
        .host_ready(host_ready), .host_reset(host_reset), .pe_irq(pe_irq),
        .pe_irq_gen(pe_irq_gen), .pe_ready(pe_ready), .pe_rd_en(pe_rd_en),
        .pe_rd_data(pe_rd_data), .pe_h2p_level(pe_h2p_level), .pe_wr_en(pe_wr_en),
        .pe_wr_data(pe_wr_data), .pe_p2h_level(pe_p2h_level)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit run_cmp = 0;

    // Reference model state
    logic [31:0] hq[$], pq[$];
    int hwp = 0, hrp = 0, pwp = 0, prp = 0;
    bit m_ie = 0, m_is = 0, m_rdy = 0, m_rst = 0, m_ovf = 0, m_udf = 0, m_peirq = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_hcsr();
        return {8'(D), 8'(hwp), 8'(hrp), 1'b0, m_udf, m_ovf, m_rst, m_rdy, 1'b0, m_is, m_ie};
    endfunction

    function automatic logic [31:0] exp_pcsr();
        return {8'(D), 8'(pwp), 8'(prp), 4'b0, pe_ready, 3'b0};
    endfunction

    // Per-clock comparison of registered outputs against the model
    always @(negedge clk) begin
        if (run_cmp) begin
            chk(host_irq == (m_ie && m_is), "R7 host_irq", 32'(host_irq), 32'(m_ie && m_is));
            chk(pe_irq == m_peirq, "R8 pe_irq", 32'(pe_irq), 32'(m_peirq));
            chk(host_ready == m_rdy && host_reset == m_rst, "R9 ready/reset",
                {30'b0, host_ready, host_reset}, {30'b0, m_rdy, m_rst});
            chk(pe_h2p_level == 8'(hwp - hrp), "R6 h2p level", 32'(pe_h2p_level), 32'(8'(hwp - hrp)));
            chk(pe_p2h_level == 8'(pwp - prp), "R6 p2h level", 32'(pe_p2h_level), 32'(8'(pwp - prp)));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // One bus/peer cycle with model update
    task automatic step(input bit wr, input bit rd, input logic [3:0] a, input logic [31:0] wd,
                        input bit ppop, input bit ppush, input logic [31:0] pd, input bit pirq,
                        input string req);
        logic [31:0] e;
        bit fh, eh, fp, ep;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        pe_rd_en = ppop; pe_wr_en = ppush; pe_wr_data = pd; pe_irq_gen = pirq;
        #1;
        if (rd) begin
            case (a)
                4'h4: e = exp_hcsr();
                4'hC: e = exp_pcsr();
                4'h8: e = (m_rst || pq.size() == 0) ? 32'd0 : pq[0];
                default: e = 32'd0;
            endcase
            chk(bus_rdata === e, req, bus_rdata, e);
        end
        if (ppop && !m_rst && hq.size() != 0)
            chk(pe_rd_data === hq[0], {req, " peer data"}, pe_rd_data, hq[0]);
        @(posedge clk);
        fh = (hq.size() == D); eh = (hq.size() == 0);
        fp = (pq.size() == D); ep = (pq.size() == 0);
        if (m_rst) begin
            hq.delete(); pq.delete();
            hwp = 0; hrp = 0; pwp = 0; prp = 0;
        end else begin
            if (wr && a == 4'h0) begin
                if (fh) m_ovf = 1;
                else begin hq.push_back(wd); hwp = (hwp + 1) % 256; end
            end
            if (ppop && !eh) begin void'(hq.pop_front()); hrp = (hrp + 1) % 256; end
            if (rd && a == 4'h8) begin
                if (ep) m_udf = 1;
                else begin void'(pq.pop_front()); prp = (prp + 1) % 256; end
            end
            if (ppush && !fp) begin pq.push_back(pd); pwp = (pwp + 1) % 256; end
        end
        m_peirq = 0;
        if (wr && a == 4'h4) begin
            m_ie = wd[0];
            if (wd[1]) m_is = 0;
            m_peirq = wd[2];
            m_rdy = wd[3];
            m_rst = wd[4];
            if (wd[5]) m_ovf = 0;
            if (wd[6]) m_udf = 0;
        end
        if (pirq) m_is = 1;
        #1;
        bus_wr = 0; bus_rd = 0; pe_rd_en = 0; pe_wr_en = 0; pe_irq_gen = 0;
    endtask

    task automatic hw(input logic [3:0] a, input logic [31:0] d, input string req);
        step(1, 0, a, d, 0, 0, 0, 0, req);
    endtask
    task automatic hr(input logic [3:0] a, input string req);
        step(0, 1, a, 0, 0, 0, 0, 0, req);
    endtask
    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, "idle");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        run_cmp = 1;
        // R10 reset state
        hr(4'h4, "R10 host csr after reset");
        hr(4'hC, "R10 peer csr after reset");
        hr(4'h0, "R3 push window reads zero");

        // R1 host-to-peer order
        for (int i = 0; i < 3; i++) hw(4'h0, 32'hA000_0000 + i, "R1 push");
        hr(4'h4, "R3 host csr pointers");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, 0, 0, "R1 peer pop");

        // R2 peer-to-host order
        step(0, 0, 0, 0, 0, 1, 32'h5555_0001, 0, "R2 peer push");
        step(0, 0, 0, 0, 0, 1, 32'h5555_0002, 0, "R2 peer push");
        pe_ready = 1;
        hr(4'hC, "R3 peer csr");
        hr(4'h8, "R2 pop first");
        hr(4'h8, "R2 pop second");
        hr(4'hC, "R2 peer csr after pops");

        // R4 overflow
        for (int i = 0; i < D; i++) hw(4'h0, 32'hC0DE_0000 + i, "R4 fill");
        hw(4'h0, 32'hDEAD_BEEF, "R4 write to full");
        hr(4'h4, "R4 overflow flag");
        hw(4'h4, 32'h20, "R4 clear overflow");
        hr(4'h4, "R4 overflow cleared");
        for (int i = 0; i < D; i++) step(0, 0, 0, 0, 1, 0, 0, 0, "R4 drain order");

        // R5 underflow
        hr(4'h8, "R5 read empty");
        hr(4'h4, "R5 underflow flag");
        hw(4'h4, 32'h40, "R5 clear underflow");
        hr(4'h4, "R5 underflow cleared");

        // R7 interrupts
        step(0, 0, 0, 0, 0, 0, 0, 1, "R7 peer irq with IE off");
        idle();
        hw(4'h4, 32'h1, "R7 enable");
        hr(4'h4, "R7 IS and IE");
        step(1, 0, 4'h4, 32'h3, 0, 0, 0, 1, "R7 set wins over clear");
        hw(4'h4, 32'h3, "R7 clear IS");
        idle();

        // R8 generate pulse
        hw(4'h4, 32'h5, "R8 IG write");
        idle();
        hr(4'h4, "R8 IG reads zero");

        // R11 writes to read-only offsets
        step(0, 0, 0, 0, 0, 1, 32'h7777_0000, 0, "R11 prefill");
        hw(4'h8, 32'hFFFF_FFFF, "R11 write pop window");
        hw(4'hC, 32'hFFFF_FFFF, "R11 write peer csr");
        hr(4'hC, "R11 peer csr unchanged");
        hr(4'h8, "R11 data unchanged");

        // R6 pointer wrap with concurrent push and pop
        hw(4'h0, 32'h0, "R6 seed");
        for (int i = 0; i < 300; i++)
            step(1, 0, 4'h0, 32'h9000_0000 + i, 1, 1, 32'h6000_0000 + i, 0, "R6 wrap h2p");
        for (int i = 0; i < 300; i++)
            step(0, 1, 4'h8, 0, 0, 1, 32'h3000_0000 + i, 0, "R6 wrap p2h");
        hr(4'h4, "R6 host csr after wrap");
        hr(4'hC, "R6 peer csr after wrap");

        // R9 reset handshake
        hw(4'h4, 32'h14, "R9 set RESET and IG");
        hw(4'h0, 32'h1234_5678, "R9 push ignored");
        hr(4'h8, "R9 pop ignored");
        hr(4'h4, "R9 host csr flushed");
        hr(4'hC, "R9 peer ready seen");
        hw(4'h4, 32'h0C, "R9 release with READY and IG");
        hw(4'h0, 32'h0BAD_F00D, "R9 push after release");
        hr(4'h4, "R9 host csr after release");
        idle();
        idle();

        run_cmp = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule